// File: doc/BRIEF.md
# Pipelined IO Bus to Ready/Valid Stream Bridge

This block is a memory-mapped peripheral on a simple pipelined processor IO bus. A bus command (read or write strobe, address, write data, byte mask) is presented for exactly one clock cycle. The bridge registers it and answers with an acknowledge one or more cycles later. The CPU may place the next command in the acknowledge cycle, so a stream of commands can complete at one word per cycle.

Behind the bus sit two ready/valid channels. The transmit channel carries words written by the CPU. The receive channel carries words that the CPU reads. A status word reports whether each channel can proceed. A single data word pushes to transmit when written and pops from receive when read. A write that cannot be delivered, or a read with nothing to return, holds back the acknowledge, so the CPU is stalled instead of losing or inventing data.

Top module: `pio_stream_bridge`

## Requirements
- R1: While rst_ni is low and right after it rises, ack_o, tx_valid_o and rx_ready_o are 0. A reset that arrives while a command is pending discards that command.
- R2: ack_o is never high in the same cycle as the command it answers. A status read (address low nibble 0x0) is acknowledged in the next cycle with rdata_o bit 0 = tx_ready_i, bit 1 = rx_valid_i, and all other bits 0.
- R3: rdata_o is all zeros in every cycle in which ack_o is low.
- R4: A write to the data word (address low nibble 0x4) raises tx_valid_o from the next cycle on. tx_data_o carries the write data with each byte lane i forced to zero when wmask_i[i] is 0. Both stay stable until tx_ready_i is high, and ack_o is asserted in exactly that cycle.
- R5: A read of the data word waits until rx_valid_i is high. In that cycle ack_o is 1, rdata_o equals rx_data_i, and rx_ready_o is high for that single cycle only.
- R6: A read of any other low-nibble offset returns zero. A write to the status word or to any other offset changes neither channel. Both are acknowledged in the next cycle.
- R7: A command issued in the cycle in which ack_o is high is accepted. Back-to-back commands complete at one acknowledge per cycle.
- R8: Only address bits [3:0] are decoded, so higher address bits do not change which register is hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address of the command |
| rd_i | input | 1 | Read command strobe, one cycle |
| wr_i | input | 1 | Write command strobe, one cycle |
| wdata_i | input | 32 | Write data |
| wmask_i | input | 4 | Write byte enables, bit i for byte i |
| rdata_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | Command acknowledge |
| tx_data_o | output | 32 | Transmit channel data |
| tx_valid_o | output | 1 | Transmit channel valid |
| tx_ready_i | input | 1 | Transmit channel ready |
| rx_data_i | input | 32 | Receive channel data |
| rx_valid_i | input | 1 | Receive channel valid |
| rx_ready_o | output | 1 | Receive channel ready, one-cycle pop |

## Verification
The hardest case to reach is a command that lands in the acknowledge cycle of a stalled predecessor. The pending write must be released and the new command captured on the same edge. The stimulus stalls a data write by holding tx_ready_i low for several cycles. It then raises it and issues the next command in that cycle. A separate sequence chains a status read, a data write and an unmapped read on consecutive cycles and checks that three acknowledges arrive on three consecutive cycles.

// File: rtl/pio_bridge_pkg.sv
package pio_bridge_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef enum logic [1:0] {
    OP_STAT_RD = 2'd0,
    OP_DATA_RD = 2'd1,
    OP_DATA_WR = 2'd2,
    OP_NOP     = 2'd3   // unmapped read or ignored write
  } op_e;

  typedef struct packed {
    logic              vld;
    op_e               op;
    logic [DATA_W-1:0] data;
  } pend_t;
endpackage

// File: rtl/pio_cmd_capture.sv
module pio_cmd_capture
  import pio_bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEC_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   wmask_i,
  input  logic              done_i,
  output pend_t             pend_o
);
  localparam logic [DEC_W-1:0] OFS_STAT = DEC_W'(0);
  localparam logic [DEC_W-1:0] OFS_DATA = DEC_W'(4);

  logic [DEC_W-1:0]  ofs;
  logic [DATA_W-1:0] wdata_m;
  logic              accept;
  op_e               op_d;
  pend_t             pend_q;

  logic unused_addr;
  assign unused_addr = ^addr_i[ADDR_W-1:DEC_W];

  assign ofs = addr_i[DEC_W-1:0];

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign wdata_m[8*b +: 8] = wmask_i[b] ? wdata_i[8*b +: 8] : 8'h00;
  end

  always_comb begin
    if (rd_i && ofs == OFS_STAT)      op_d = OP_STAT_RD;
    else if (rd_i && ofs == OFS_DATA) op_d = OP_DATA_RD;
    else if (wr_i && ofs == OFS_DATA) op_d = OP_DATA_WR;
    else                              op_d = OP_NOP;
  end

  // new command is taken when idle or in the ack cycle of the current one
  assign accept = (rd_i || wr_i) && (!pend_q.vld || done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '{vld: 1'b0, op: OP_NOP, data: '0};
    end else if (accept) begin
      pend_q <= '{vld: 1'b1, op: op_d, data: wdata_m};
    end else if (done_i) begin
      pend_q.vld <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pio_resp_unit.sv
module pio_resp_unit
  import pio_bridge_pkg::*;
(
  input  pend_t             pend_i,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              rx_ready_o
);
  always_comb begin
    ack_o      = 1'b0;
    rdata_o    = '0;
    tx_valid_o = 1'b0;
    rx_ready_o = 1'b0;
    if (pend_i.vld) begin
      unique case (pend_i.op)
        OP_STAT_RD: begin
          ack_o   = 1'b1;
          rdata_o = {{(DATA_W-2){1'b0}}, rx_valid_i, tx_ready_i};
        end
        OP_DATA_RD: begin
          ack_o      = rx_valid_i;
          rx_ready_o = rx_valid_i;
          rdata_o    = rx_valid_i ? rx_data_i : '0;
        end
        OP_DATA_WR: begin
          tx_valid_o = 1'b1;
          ack_o      = tx_ready_i;
        end
        default: ack_o = 1'b1;
      endcase
    end
  end

  assign tx_data_o = pend_i.data;
endmodule

// File: rtl/pio_stream_bridge.sv
module pio_stream_bridge
  import pio_bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEC_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wmask_i,
  output logic [31:0]       rdata_o,
  output logic              ack_o,
  output logic [31:0]       tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [31:0]       rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o
);
  pend_t pend;

  pio_cmd_capture #(.ADDR_W(ADDR_W), .DEC_W(DEC_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .wmask_i (wmask_i),
    .done_i  (ack_o),
    .pend_o  (pend)
  );

  pio_resp_unit u_resp (
    .pend_i     (pend),
    .tx_ready_i (tx_ready_i),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .ack_o      (ack_o),
    .rdata_o    (rdata_o),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .rx_ready_o (rx_ready_o)
  );

  // R2
  ack_has_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($past(rd_i || wr_i) || $past(pend.vld && !ack_o)));

  // R3
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> rdata_o == '0);

  // R4
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R4
  tx_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (ack_o == tx_ready_i));

  // R5
  rx_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> (ack_o && rx_valid_i && rdata_o == rx_data_i));

  // R5
  rx_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_ready_o && tx_valid_o));
endmodule

// File: tb/pio_stream_bridge_tb.sv
module pio_stream_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wmask = '0;
  logic [31:0] rdata;
  logic        ack;
  logic [31:0] tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  pio_stream_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .wmask_i(wmask), .rdata_o(rdata), .ack_o(ack),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [3:0]  mask;
    logic        txr;
    logic        rxv;
    logic [31:0] rxd;
    logic [31:0] e_rdata;
    logic        e_txv;
    logic [31:0] e_txd;
    logic        e_rxr;
  } vec_t;

  // rd wr addr wdata mask txr rxv rxd | rdata txv txd rxr
  localparam vec_t VECS [10] = '{
    '{1'b1,1'b0,8'h00,32'h0,4'h0,1'b1,1'b0,32'h0,        32'h1,1'b0,32'h0,1'b0},        // R2
    '{1'b1,1'b0,8'h00,32'h0,4'h0,1'b0,1'b1,32'h0,        32'h2,1'b0,32'h0,1'b0},        // R2
    '{1'b1,1'b0,8'h00,32'h0,4'h0,1'b1,1'b1,32'h0,        32'h3,1'b0,32'h0,1'b0},        // R2
    '{1'b0,1'b1,8'h04,32'hA5A51234,4'hF,1'b1,1'b0,32'h0, 32'h0,1'b1,32'hA5A51234,1'b0}, // R4
    '{1'b0,1'b1,8'h04,32'hDEADBEEF,4'h5,1'b1,1'b0,32'h0, 32'h0,1'b1,32'h00AD00EF,1'b0}, // R4
    '{1'b1,1'b0,8'h04,32'h0,4'h0,1'b0,1'b1,32'h12345678, 32'h12345678,1'b0,32'h0,1'b1}, // R5
    '{1'b1,1'b0,8'h08,32'h0,4'h0,1'b1,1'b1,32'h55555555, 32'h0,1'b0,32'h0,1'b0},        // R6
    '{1'b0,1'b1,8'h00,32'h77777777,4'hF,1'b1,1'b0,32'h0, 32'h0,1'b0,32'h0,1'b0},        // R6
    '{1'b1,1'b0,8'h14,32'h0,4'h0,1'b0,1'b1,32'hCAFEF00D, 32'hCAFEF00D,1'b0,32'h0,1'b1}, // R8
    '{1'b1,1'b0,8'hF0,32'h0,4'h0,1'b1,1'b0,32'h0,        32'h1,1'b0,32'h0,1'b0}         // R8
  };

  task automatic issue(input logic r, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic [3:0] m);
    rd = r; wr = w; addr = a; wdata = d; wmask = m;
  endtask

  task automatic idle_bus();
    rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0; wmask = '0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #5;
    chk("R1 ack in reset", {31'b0, ack}, 32'h0);
    chk("R1 tx_valid in reset", {31'b0, tx_valid}, 32'h0);
    chk("R1 rx_ready in reset", {31'b0, rx_ready}, 32'h0);
    chk("R3 rdata in reset", rdata, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk); #5;
    chk("R1 ack after reset", {31'b0, ack}, 32'h0);

    // table walk
    foreach (VECS[i]) begin
      @(negedge clk);
      issue(VECS[i].rd, VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].mask);
      tx_ready = VECS[i].txr; rx_valid = VECS[i].rxv; rx_data = VECS[i].rxd;
      #5;
      chk($sformatf("R2 no ack in cmd cycle v%0d", i), {31'b0, ack}, 32'h0);
      @(negedge clk);
      idle_bus();
      #5;
      chk($sformatf("R2 ack next cycle v%0d", i), {31'b0, ack}, 32'h1);
      chk($sformatf("R2/R5/R6/R8 rdata v%0d", i), rdata, VECS[i].e_rdata);
      chk($sformatf("R4/R6 tx_valid v%0d", i), {31'b0, tx_valid}, {31'b0, VECS[i].e_txv});
      if (VECS[i].e_txv) chk($sformatf("R4 tx_data v%0d", i), tx_data, VECS[i].e_txd);
      chk($sformatf("R5 rx_ready v%0d", i), {31'b0, rx_ready}, {31'b0, VECS[i].e_rxr});
    end
    @(negedge clk);
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0;
    #5;
    chk("R3 rdata idle", rdata, 32'h0);

    // R4: write stall, then back-to-back command in the ack cycle (R7)
    @(negedge clk);
    issue(1'b0, 1'b1, 8'h04, 32'h0BADF00D, 4'hF);
    @(negedge clk);
    idle_bus();
    for (int k = 0; k < 3; k++) begin
      #5;
      chk("R4 stalled ack", {31'b0, ack}, 32'h0);
      chk("R4 stalled tx_valid", {31'b0, tx_valid}, 32'h1);
      chk("R4 stalled tx_data", tx_data, 32'h0BADF00D);
      @(negedge clk);
    end
    tx_ready = 1'b1;
    issue(1'b1, 1'b0, 8'h00, 32'h0, 4'h0);
    #5;
    chk("R4 ack on tx_ready", {31'b0, ack}, 32'h1);
    @(negedge clk);
    idle_bus();
    #5;
    chk("R7 cmd in stalled ack cycle acked", {31'b0, ack}, 32'h1);
    chk("R7 status after stall", rdata, 32'h1);
    chk("R6 no tx after accept", {31'b0, tx_valid}, 32'h0);
    @(negedge clk);
    tx_ready = 1'b0;

    // R5: read stall
    @(negedge clk);
    issue(1'b1, 1'b0, 8'h04, 32'h0, 4'h0);
    @(negedge clk);
    idle_bus();
    for (int k = 0; k < 3; k++) begin
      #5;
      chk("R5 stalled ack", {31'b0, ack}, 32'h0);
      chk("R5 stalled rx_ready", {31'b0, rx_ready}, 32'h0);
      chk("R3 stalled rdata", rdata, 32'h0);
      @(negedge clk);
    end
    rx_valid = 1'b1; rx_data = 32'h600DCAFE;
    #5;
    chk("R5 ack on rx_valid", {31'b0, ack}, 32'h1);
    chk("R5 rdata on rx_valid", rdata, 32'h600DCAFE);
    chk("R5 rx_ready pulse", {31'b0, rx_ready}, 32'h1);
    @(negedge clk);
    #5;
    chk("R5 rx_ready single cycle", {31'b0, rx_ready}, 32'h0);
    chk("R5 no second ack", {31'b0, ack}, 32'h0);
    rx_valid = 1'b0;

    // R7: three consecutive commands, three consecutive acks
    tx_ready = 1'b1;
    @(negedge clk);
    issue(1'b1, 1'b0, 8'h00, 32'h0, 4'h0);
    @(negedge clk);
    issue(1'b0, 1'b1, 8'h04, 32'h13572468, 4'hF);
    #5;
    chk("R7 ack 1", {31'b0, ack}, 32'h1);
    chk("R7 status 1", rdata, 32'h1);
    @(negedge clk);
    issue(1'b1, 1'b0, 8'h0C, 32'h0, 4'h0);
    #5;
    chk("R7 ack 2", {31'b0, ack}, 32'h1);
    chk("R7 tx_data 2", tx_data, 32'h13572468);
    @(negedge clk);
    idle_bus();
    #5;
    chk("R7 ack 3", {31'b0, ack}, 32'h1);
    chk("R6 unmapped read 3", rdata, 32'h0);
    @(negedge clk);
    #5;
    chk("R7 idle after burst", {31'b0, ack}, 32'h0);
    tx_ready = 1'b0;

    // R1: reset while a write is pending
    @(negedge clk);
    issue(1'b0, 1'b1, 8'h04, 32'hFEEDFACE, 4'hF);
    @(negedge clk);
    idle_bus();
    #5;
    chk("R1 pending before reset", {31'b0, tx_valid}, 32'h1);
    rst_ni = 1'b0;
    #1;
    chk("R1 tx_valid cleared by reset", {31'b0, tx_valid}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    tx_ready = 1'b1;
    @(negedge clk); #5;
    chk("R1 no ack for discarded cmd", {31'b0, ack}, 32'h0);
    chk("R1 no tx after reset", {31'b0, tx_valid}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule